// File: doc/BRIEF.md
# Dual Converter-Shared Digital I/O Port

This block controls two small digital I/O ports, QA and QB, whose pads are shared with an analog converter. Each port keeps a per-pin direction register and an output latch. From these it drives the pad output-enable and output-value lines. A simple register bus writes both registers and reads back either the direction bits or a per-pin data view.

Two mode inputs from the converter control logic take priority over the stored direction bits on port QA.

- **External-multiplexer mode:** QA pins 1:0 become outputs. They carry a two-bit multiplexer address.
- **Trigger mode:** QA pins 3 and 4 become inputs. Their synchronized levels are passed on as two trigger signals.

In both modes, data reads of the affected bits return the overriding signal, not the latch. Clearing a mode hands the pins back to the stored direction bits on the next clock.

Top module: `aport_ctrl`

## Requirements
- R1: A direction bit of 1 sets the matching pad output enable, and 0 clears it. Direction registers read back at address 2 (QA) and address 3 (QB).
- R2: Synchronous reset clears both direction registers and both mode flops. In the first cycle after reset every pad output enable is low and the trigger outputs are zero.
- R3: One clock after `mux_mode` is sampled high, QA pins 1:0 are output-enabled whatever their direction bits, and `qa_pad_out[1:0]` carries the `ma_addr` value sampled on that edge.
- R4: While the multiplexer mode is active, a read of address 0 returns the driven address in bits 1:0, whatever their direction bits.
- R5: One clock after `trig_mode` is sampled high, QA pins 3 and 4 are forced to inputs. `trig_out[0]` then follows the synchronized level of pin 3, and `trig_out[1]` follows pin 4. Outside trigger mode, `trig_out` is zero.
- R6: While trigger mode is active, bits 3 and 4 of an address-0 read return the synchronized pad levels, whatever their direction bits.
- R7: A data read (address 0 = QA, address 1 = QB) returns the output latch for pins whose direction bit is 1, and the synchronized pad level for pins whose direction bit is 0.
- R8: QA implements only bits 0, 1, 3 and 4. QA bit 2, QA bits 7:5 and QB bits 7:4 always read zero, ignore writes, and are never output-enabled.
- R9: A pad input change reaches reads and trigger outputs only after two rising clock edges.
- R10: One clock after a mode input is sampled low, the affected pins again follow their stored direction bits.
- R11: Reset leaves the output latches unchanged. A value written before reset is still driven once a pin is later made an output.
- R12: Writes to the QA data register while a mode overrides those pins still update the latch. The new value appears on the pads and on reads once the mode ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 QA data, 1 QB data, 2 QA direction, 3 QB direction |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| mux_mode | input | 1 | External-multiplexer mode request |
| ma_addr | input | 2 | Multiplexer address to drive on QA pins 1:0 |
| trig_mode | input | 1 | Trigger mode request |
| qa_pad_in | input | 5 | QA pad input levels |
| qa_pad_oe | output | 5 | QA pad output enables |
| qa_pad_out | output | 5 | QA pad output values |
| qb_pad_in | input | 4 | QB pad input levels |
| qb_pad_oe | output | 4 | QB pad output enables |
| qb_pad_out | output | 4 | QB pad output values |
| trig_out | output | 2 | Trigger signals taken from QA pins 3 and 4 |

## Verification
The bench builds the block with its default parameters: a five-pin QA port with bit 2 left unimplemented, a four-pin QB port, and a two-stage input synchronizer. With these values it can reach the following cases:

- the gap bit inside QA;
- both overrides acting on the same port at once, with opposing forced directions;
- an observable one-edge versus two-edge boundary on pad inputs.

Directed sequences enter and leave each mode while the latch is being written, and a mid-run reset shows that the latch contents survive.

// File: rtl/aport_pkg.sv
package aport_pkg;

    localparam int BUS_W    = 8;
    localparam int ADDR_W   = 2;
    localparam int QA_PINS  = 5;
    localparam int QB_PINS  = 4;
    localparam int SYNC_LEN = 2;

    // positions of the special-function pins on port QA
    localparam int MA_LSB   = 0;
    localparam int TRIG_LSB = 3;

    localparam logic [QA_PINS-1:0] QA_IMPL = 5'b11011;
    localparam logic [QB_PINS-1:0] QB_IMPL = 4'b1111;

    typedef enum logic [ADDR_W-1:0] {
        SEL_QA_DATA = 2'd0,
        SEL_QB_DATA = 2'd1,
        SEL_QA_DIR  = 2'd2,
        SEL_QB_DIR  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       mux_on;
        logic       trig_on;
        logic [1:0] ma;
    } mode_t;

endpackage

// File: rtl/aport_sync.sv
module aport_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];

    if (STAGES == 2) begin : g_chk
        // R9: pad level becomes visible exactly two edges later
        assert_two_edge_R9: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(rst, 2)) |-> (dout == $past(din, 2)));
    end

endmodule

// File: rtl/aport_bank.sv
module aport_bank #(
    parameter int             W    = 4,
    parameter logic [W-1:0]   IMPL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dir_we,
    input  logic         data_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] latch_q
);

    // direction: cleared by reset, unimplemented bits never set
    always_ff @(posedge clk) begin
        if (rst)         dir_q <= '0;
        else if (dir_we) dir_q <= wdata & IMPL;
    end

    // output latch: survives reset, keeps the last written value
    always_ff @(posedge clk) begin
        if (data_we) latch_q <= wdata & IMPL;
    end

    // R8: a gap bit never becomes an output
    assert_gap_dir_R8: assert property (@(posedge clk) disable iff (rst)
        (dir_q & ~IMPL) == '0);

endmodule

// File: rtl/aport_override.sv
module aport_override
    import aport_pkg::*;
#(
    parameter int             W    = QA_PINS,
    parameter logic [W-1:0]   IMPL = QA_IMPL
) (
    input  mode_t        mode,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] pad_sync,
    output logic [W-1:0] oe,
    output logic [W-1:0] pout,
    output logic [W-1:0] view,
    output logic [1:0]   trig
);

    logic [W-1:0] oe_raw, pout_raw, view_raw;

    always_comb begin
        oe_raw   = dir_q;
        pout_raw = latch_q;
        view_raw = (dir_q & latch_q) | (~dir_q & pad_sync);
        if (mode.mux_on) begin
            oe_raw[MA_LSB +: 2]   = 2'b11;
            pout_raw[MA_LSB +: 2] = mode.ma;
            view_raw[MA_LSB +: 2] = mode.ma;
        end
        if (mode.trig_on) begin
            oe_raw[TRIG_LSB +: 2]   = 2'b00;
            view_raw[TRIG_LSB +: 2] = pad_sync[TRIG_LSB +: 2];
        end
        oe   = oe_raw & IMPL;
        pout = pout_raw & IMPL;
        view = view_raw & IMPL;
        trig = mode.trig_on ? pad_sync[TRIG_LSB +: 2] : 2'b00;
    end

endmodule

// File: rtl/aport_ctrl.sv
module aport_ctrl
    import aport_pkg::*;
#(
    parameter int QA_W = QA_PINS,
    parameter int QB_W = QB_PINS,
    parameter int DW   = BUS_W,
    parameter int SYNC = SYNC_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              mux_mode,
    input  logic [1:0]        ma_addr,
    input  logic              trig_mode,
    input  logic [QA_W-1:0]   qa_pad_in,
    output logic [QA_W-1:0]   qa_pad_oe,
    output logic [QA_W-1:0]   qa_pad_out,
    input  logic [QB_W-1:0]   qb_pad_in,
    output logic [QB_W-1:0]   qb_pad_oe,
    output logic [QB_W-1:0]   qb_pad_out,
    output logic [1:0]        trig_out
);

    localparam logic [QA_W-1:0] QA_MASK = QA_W'(QA_IMPL);
    localparam logic [QB_W-1:0] QB_MASK = QB_W'(QB_IMPL);

    reg_sel_e        sel;
    mode_t           mode_q;
    logic [QA_W-1:0] qa_sync, qa_dir, qa_latch, qa_view;
    logic [QB_W-1:0] qb_sync, qb_dir, qb_latch, qb_view;

    assign sel = reg_sel_e'(bus_addr);

    // mode inputs take effect one clock after they are sampled
    always_ff @(posedge clk) begin
        if (rst) mode_q <= '0;
        else     mode_q <= '{mux_on: mux_mode, trig_on: trig_mode, ma: ma_addr};
    end

    aport_sync #(.W(QA_W), .STAGES(SYNC)) i_qa_sync (
        .clk(clk), .rst(rst), .din(qa_pad_in), .dout(qa_sync));

    aport_sync #(.W(QB_W), .STAGES(SYNC)) i_qb_sync (
        .clk(clk), .rst(rst), .din(qb_pad_in), .dout(qb_sync));

    aport_bank #(.W(QA_W), .IMPL(QA_MASK)) i_qa_bank (
        .clk(clk), .rst(rst),
        .dir_we (bus_we && sel == SEL_QA_DIR),
        .data_we(bus_we && sel == SEL_QA_DATA),
        .wdata  (bus_wdata[QA_W-1:0]),
        .dir_q  (qa_dir), .latch_q(qa_latch));

    aport_bank #(.W(QB_W), .IMPL(QB_MASK)) i_qb_bank (
        .clk(clk), .rst(rst),
        .dir_we (bus_we && sel == SEL_QB_DIR),
        .data_we(bus_we && sel == SEL_QB_DATA),
        .wdata  (bus_wdata[QB_W-1:0]),
        .dir_q  (qb_dir), .latch_q(qb_latch));

    aport_override #(.W(QA_W), .IMPL(QA_MASK)) i_qa_ovr (
        .mode(mode_q), .dir_q(qa_dir), .latch_q(qa_latch), .pad_sync(qa_sync),
        .oe(qa_pad_oe), .pout(qa_pad_out), .view(qa_view), .trig(trig_out));

    // port QB has no special functions
    assign qb_pad_oe  = qb_dir;
    assign qb_pad_out = qb_latch;
    assign qb_view    = ((qb_dir & qb_latch) | (~qb_dir & qb_sync)) & QB_MASK;

    always_comb begin
        unique case (sel)
            SEL_QA_DATA: bus_rdata = DW'(qa_view);
            SEL_QB_DATA: bus_rdata = DW'(qb_view);
            SEL_QA_DIR:  bus_rdata = DW'(qa_dir);
            SEL_QB_DIR:  bus_rdata = DW'(qb_dir);
            default:     bus_rdata = '0;
        endcase
    end

    // R2: all pads start as inputs, no trigger activity
    assert_reset_inputs_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (qa_pad_oe == '0 && qb_pad_oe == '0 && trig_out == 2'b00));

    // R3: multiplexer pins forced to outputs carrying the sampled address
    assert_mux_drive_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(mux_mode) && !$past(rst)) |->
        (qa_pad_oe[MA_LSB +: 2] == 2'b11 && qa_pad_out[MA_LSB +: 2] == $past(ma_addr)));

    // R5: trigger pins forced to inputs and fed from the synchronizer
    assert_trig_input_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(trig_mode) && !$past(rst)) |->
        (qa_pad_oe[TRIG_LSB +: 2] == 2'b00 && trig_out == qa_sync[TRIG_LSB +: 2]));

    // R10: with both modes off the stored direction bits rule the pads
    assert_dir_restored_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(mux_mode) && !$past(trig_mode) && !$past(rst)) |->
        (qa_pad_oe == qa_dir && trig_out == 2'b00));

    // R8: unimplemented QA bits never read back as set
    assert_gap_read_R8: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_QA_DATA) |-> ((bus_rdata & ~DW'(QA_MASK)) == '0));

endmodule

// File: tb/test_aport_ctrl.sv
module test_aport_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       mux_mode = 1'b0;
    logic [1:0] ma_addr = 2'b00;
    logic       trig_mode = 1'b0;
    logic [4:0] qa_pad_in = 5'd0;
    logic [4:0] qa_pad_oe, qa_pad_out;
    logic [3:0] qb_pad_in = 4'd0;
    logic [3:0] qb_pad_oe, qb_pad_out;
    logic [1:0] trig_out;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    aport_ctrl i_aport_ctrl (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mux_mode(mux_mode), .ma_addr(ma_addr), .trig_mode(trig_mode),
        .qa_pad_in(qa_pad_in), .qa_pad_oe(qa_pad_oe), .qa_pad_out(qa_pad_out),
        .qb_pad_in(qb_pad_in), .qb_pad_oe(qb_pad_oe), .qb_pad_out(qb_pad_out),
        .trig_out(trig_out));

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic t_reset;
        chk("R2 qa oe after reset", 8'(qa_pad_oe), 8'h00);
        chk("R2 qb oe after reset", 8'(qb_pad_oe), 8'h00);
        chk("R2 trig after reset", 8'(trig_out), 8'h00);
        rd(2'd2, 8'h00, "R2 qa dir after reset");
        rd(2'd3, 8'h00, "R2 qb dir after reset");
    endtask

    task automatic t_dir;
        wr(2'd2, 8'hFF);
        rd(2'd2, 8'h1B, "R1 R8 qa dir readback");
        chk("R1 R8 qa oe", 8'(qa_pad_oe), 8'h1B);
        wr(2'd3, 8'h05);
        rd(2'd3, 8'h05, "R1 qb dir readback");
        chk("R1 qb oe", 8'(qb_pad_oe), 8'h05);
    endtask

    task automatic t_data;
        wr(2'd1, 8'hFF);
        qb_pad_in = 4'b0000;
        tick(2);
        rd(2'd1, 8'h05, "R7 qb mixed read, pads low");
        chk("R7 qb pad out", 8'(qb_pad_out), 8'h0F);
        qb_pad_in = 4'b1010;
        tick(2);
        rd(2'd1, 8'h0F, "R7 qb mixed read, pads high");
        wr(2'd2, 8'h03);
        wr(2'd0, 8'h02);
        qa_pad_in = 5'b11000;
        tick(2);
        rd(2'd0, 8'h1A, "R7 qa mixed read");
        chk("R7 qa pad out", 8'(qa_pad_out), 8'h02);
    endtask

    task automatic t_sync;
        wr(2'd3, 8'h00);
        qb_pad_in = 4'h0;
        tick(2);
        qb_pad_in = 4'h9;
        tick(1);
        rd(2'd1, 8'h00, "R9 one edge not yet visible");
        tick(1);
        rd(2'd1, 8'h09, "R9 visible after two edges");
    endtask

    task automatic t_gap;
        wr(2'd2, 8'h00);
        wr(2'd0, 8'hFF);
        wr(2'd2, 8'hFF);
        qa_pad_in = 5'b00100;
        tick(2);
        rd(2'd0, 8'h1B, "R8 gap bits read zero, outputs");
        chk("R8 gap never enabled", 8'(qa_pad_oe), 8'h1B);
        wr(2'd2, 8'h00);
        qa_pad_in = 5'b11111;
        tick(2);
        rd(2'd0, 8'h1B, "R8 gap bit read zero, inputs");
    endtask

    task automatic t_mux;
        qa_pad_in = 5'd0;
        tick(2);
        mux_mode = 1'b1; ma_addr = 2'b10;
        tick(1);
        chk("R3 mux oe forced", 8'(qa_pad_oe), 8'h03);
        chk("R3 mux address driven", 8'(qa_pad_out[1:0]), 8'h02);
        rd(2'd0, 8'h02, "R4 mux read returns address");
        ma_addr = 2'b01;
        tick(1);
        chk("R3 mux address follows", 8'(qa_pad_out[1:0]), 8'h01);
        rd(2'd0, 8'h01, "R4 mux read follows address");
        wr(2'd0, 8'h00);
        rd(2'd0, 8'h01, "R12 write hidden while mux active");
        mux_mode = 1'b0;
        tick(1);
        chk("R10 mux released to dir", 8'(qa_pad_oe), 8'h00);
        wr(2'd2, 8'h03);
        chk("R12 latch written during mux", 8'(qa_pad_out[1:0]), 8'h00);
        rd(2'd0, 8'h00, "R12 read after mux exit");
    endtask

    task automatic t_trig;
        wr(2'd2, 8'h18);
        wr(2'd0, 8'h08);
        qa_pad_in = 5'b10000;
        tick(2);
        rd(2'd0, 8'h08, "R7 trig pins as outputs");
        chk("R1 trig pins oe before mode", 8'(qa_pad_oe), 8'h18);
        trig_mode = 1'b1;
        tick(1);
        chk("R5 trig pins forced inputs", 8'(qa_pad_oe), 8'h00);
        chk("R5 trig out from pads", 8'(trig_out), 8'h02);
        rd(2'd0, 8'h10, "R6 trig read returns pads");
        qa_pad_in = 5'b01000;
        tick(2);
        chk("R5 trig out follows pads", 8'(trig_out), 8'h01);
        rd(2'd0, 8'h08, "R6 trig read follows pads");
        mux_mode = 1'b1; ma_addr = 2'b11;
        tick(1);
        chk("R3 R5 both modes oe", 8'(qa_pad_oe), 8'h03);
        mux_mode = 1'b0; trig_mode = 1'b0;
        tick(1);
        chk("R10 trig released to dir", 8'(qa_pad_oe), 8'h18);
        chk("R5 trig out idle", 8'(trig_out), 8'h00);
        rd(2'd0, 8'h08, "R10 read from latch again");
    endtask

    task automatic t_rst_latch;
        wr(2'd3, 8'h00);
        wr(2'd1, 8'h06);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        chk("R2 qb oe after second reset", 8'(qb_pad_oe), 8'h00);
        wr(2'd3, 8'h0F);
        rd(2'd1, 8'h06, "R11 latch kept over reset");
        chk("R11 pad out kept over reset", 8'(qb_pad_out), 8'h06);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        t_reset();
        t_dir();
        t_data();
        t_sync();
        t_gap();
        t_mux();
        t_trig();
        t_rst_latch();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule